// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address that a synchronous burst memory array uses. A burst starts when one of two address strobes is accepted. Both strobes load the external address into an output register. Each later cycle in which the advance input is high and no strobe is present moves the two low address bits to the next position in the burst. A burst covers at most four words. A mode input chooses the order of the low bits: counting order or XOR order.

Every input is sampled on the rising clock edge. The output address is a register and changes one edge after the cycle that causes the change. The two strobes are qualified differently:

- The processor-side strobe needs only the primary chip enable, bit 0 of `chip_en`. It has priority over the controller-side strobe.
- The controller-side strobe needs every chip enable to be high.

When a strobe is present but its qualification fails, the cycle is ignored. The address holds, and the advance input has no effect in that cycle.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst_n` is low, and after reset is released, `mem_addr` is zero until the first load or step. The burst count also starts at zero.
- R2: When `strobe_proc` is high and `chip_en[0]` is high, `mem_addr` equals `ext_addr` after the next edge. This holds whatever the values of `strobe_ctl`, `advance` and the other enable bits.
- R3: When R2 does not apply, and `strobe_ctl` is high with every bit of `chip_en` high, `mem_addr` equals `ext_addr` after the next edge. This load resets the burst count to zero.
- R4: A cycle with either strobe high that loads under neither R2 nor R3 leaves `mem_addr` unchanged, even when `advance` is high.
- R5: With no strobe, `advance` high and `order_il` = 0, the low two bits become (start low bits + count) mod 4. The count is the number of steps taken since the load, including this step. A start of 2 gives 2, 3, 0, 1.
- R6: With no strobe, `advance` high and `order_il` = 1, the low two bits become (start low bits) XOR count. A start of 1 gives 1, 0, 3, 2.
- R7: Stepping never changes `mem_addr[AW-1:2]`. Stepping from low bits 3 to 0 does not carry into the upper bits.
- R8: After three steps, later advance cycles leave `mem_addr` unchanged until the next load.
- R9: A cycle with no strobe and `advance` low leaves `mem_addr` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_addr | input | AW | Burst start address |
| strobe_proc | input | 1 | Processor-side load strobe, active high |
| strobe_ctl | input | 1 | Controller-side load strobe, active high |
| chip_en | input | NCE | Chip enables, active high; bit 0 is the primary enable |
| advance | input | 1 | Step to the next burst address |
| order_il | input | 1 | 0 = counting order, 1 = XOR order |
| mem_addr | output | AW | Registered address to the memory array |

## Verification
The hardest cases to reach from the ports are those where a strobe is present but not qualified, while advance is high in the same cycle. One example is the controller strobe with a single secondary enable low. Another is the processor strobe with the primary enable low. Both cycles must look like a hold rather than a step. The bench drives both cases directly after a burst has taken one step, so that a wrongly taken step would show in the low bits. A randomized phase then mixes strobes, enables, advance and mode every cycle against the cycle-by-cycle model, to reach saturated bursts and mode changes in the middle of a burst.

// File: rtl/burst_addr_seq_pkg.sv
// Package: shared action type and the burst ordering function.
// Assumes a burst length that is a power of two.
package burst_addr_seq_pkg;

    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_LOAD = 2'd1,
        ACT_STEP = 2'd2
    } seq_act_t;

    // Maps start low bits and count to the low address bits for one order.
    function automatic logic [1:0] order_low(input logic [1:0] start_lo,
                                             input logic [1:0] count,
                                             input logic       il);
        order_low = il ? (start_lo ^ count) : (start_lo + count);
    endfunction

endpackage

// File: rtl/burst_seq_decode.sv
// Module: burst_seq_decode
// Decides whether a cycle loads, steps or holds. The processor strobe is
// qualified by enable bit 0 and wins. The controller strobe needs every
// enable. Any strobe blocks stepping. Assumes NCE >= 1.
module burst_seq_decode
    import burst_addr_seq_pkg::*;
#(
    parameter int NCE = 3
) (
    input  logic           strobe_proc,
    input  logic           strobe_ctl,
    input  logic [NCE-1:0] chip_en,
    input  logic           advance,
    input  logic           cnt_full,
    output seq_act_t       act
);
    logic proc_ok;
    logic ctl_ok;

    assign proc_ok = strobe_proc && chip_en[0];
    assign ctl_ok  = strobe_ctl && (&chip_en);

    // Priority decision for this cycle.
    always_comb begin
        if (proc_ok || ctl_ok)
            act = ACT_LOAD;
        else if (!strobe_proc && !strobe_ctl && advance && !cnt_full)
            act = ACT_STEP;
        else
            act = ACT_HOLD;
    end
endmodule

// File: rtl/burst_seq_counter.sv
// Module: burst_seq_counter
// Holds the low bits of the burst start and the step count. The count
// stops at BURST_LEN-1. Assumes LOW_W = log2(BURST_LEN).
module burst_seq_counter
    import burst_addr_seq_pkg::*;
#(
    parameter int LOW_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  seq_act_t         act,
    input  logic [LOW_W-1:0] load_lo,
    output logic [LOW_W-1:0] start_lo,
    output logic [LOW_W-1:0] count,
    output logic [LOW_W-1:0] count_nxt,
    output logic             cnt_full
);
    localparam logic [LOW_W-1:0] CNT_MAX = {LOW_W{1'b1}};

    assign cnt_full  = (count == CNT_MAX);
    assign count_nxt = count + 1'b1;

    // Capture the start bits on a load; advance the count on a step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_lo <= '0;
            count    <= '0;
        end else if (act == ACT_LOAD) begin
            start_lo <= load_lo;
            count    <= '0;
        end else if (act == ACT_STEP) begin
            count    <= count_nxt;
        end
    end
endmodule

// File: rtl/burst_seq_order.sv
// Module: burst_seq_order
// Combinational: forms the low address bits for a given count in the
// selected order. Assumes LOW_W = 2, the width of the ordering function.
module burst_seq_order
    import burst_addr_seq_pkg::*;
#(
    parameter int LOW_W = 2
) (
    input  logic [LOW_W-1:0] start_lo,
    input  logic [LOW_W-1:0] count,
    input  logic             order_il,
    output logic [LOW_W-1:0] low_out
);
    // Apply the ordering rule.
    always_comb low_out = order_low(start_lo, count, order_il);
endmodule

// File: rtl/burst_addr_seq.sv
// Module: burst_addr_seq (top)
// Loads a start address on a qualified strobe, then steps the two low bits
// in counting or XOR order for up to three advance cycles. The upper bits
// stay fixed. The output is a register.
// Assumes BURST_LEN = 4 and AW > 2.
module burst_addr_seq
    import burst_addr_seq_pkg::*;
#(
    parameter int AW        = 18,
    parameter int NCE       = 3,
    parameter int BURST_LEN = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [AW-1:0]  ext_addr,
    input  logic           strobe_proc,
    input  logic           strobe_ctl,
    input  logic [NCE-1:0] chip_en,
    input  logic           advance,
    input  logic           order_il,
    output logic [AW-1:0]  mem_addr
);
    localparam int LOW_W = $clog2(BURST_LEN);

    seq_act_t         act;
    logic             cnt_full;
    logic [LOW_W-1:0] start_lo;
    logic [LOW_W-1:0] count;
    logic [LOW_W-1:0] count_nxt;
    logic [LOW_W-1:0] low_nxt;

    burst_seq_decode #(.NCE(NCE)) u_decode (
        .strobe_proc (strobe_proc),
        .strobe_ctl  (strobe_ctl),
        .chip_en     (chip_en),
        .advance     (advance),
        .cnt_full    (cnt_full),
        .act         (act)
    );

    burst_seq_counter #(.LOW_W(LOW_W)) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .act       (act),
        .load_lo   (ext_addr[LOW_W-1:0]),
        .start_lo  (start_lo),
        .count     (count),
        .count_nxt (count_nxt),
        .cnt_full  (cnt_full)
    );

    burst_seq_order #(.LOW_W(LOW_W)) u_order (
        .start_lo (start_lo),
        .count    (count_nxt),
        .order_il (order_il),
        .low_out  (low_nxt)
    );

    // Output register: load the full address or replace only the low bits.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mem_addr <= '0;
        else if (act == ACT_LOAD)
            mem_addr <= ext_addr;
        else if (act == ACT_STEP)
            mem_addr <= {mem_addr[AW-1:LOW_W], low_nxt};
    end
endmodule

// File: rtl/burst_addr_seq_chk.sv
// Module: burst_addr_seq_chk
// Port-level properties for burst_addr_seq, attached by bind. Keeps its
// own step count and order flags, built from the ports only.
module burst_addr_seq_chk #(
    parameter int AW  = 18,
    parameter int NCE = 3
) (
    input logic           clk,
    input logic           rst_n,
    input logic [AW-1:0]  ext_addr,
    input logic           strobe_proc,
    input logic           strobe_ctl,
    input logic [NCE-1:0] chip_en,
    input logic           advance,
    input logic           order_il,
    input logic [AW-1:0]  mem_addr
);
    logic       ld;
    logic       quiet;
    logic [1:0] steps;
    logic       lin_only;
    logic       il_only;

    assign ld    = (strobe_proc && chip_en[0]) || (strobe_ctl && (&chip_en));
    assign quiet = !strobe_proc && !strobe_ctl;

    // Track accepted steps and the orders used since the last load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            steps <= 2'd0; lin_only <= 1'b1; il_only <= 1'b1;
        end else if (ld) begin
            steps <= 2'd0; lin_only <= 1'b1; il_only <= 1'b1;
        end else if (quiet && advance && steps != 2'd3) begin
            steps <= steps + 2'd1;
            if (order_il) lin_only <= 1'b0;
            else          il_only  <= 1'b0;
        end
    end

    p_load_proc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_proc && chip_en[0]) |=> mem_addr == $past(ext_addr));

    p_load_ctl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!(strobe_proc && chip_en[0]) && strobe_ctl && (&chip_en))
        |=> mem_addr == $past(ext_addr));

    p_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld && !quiet) |=> $stable(mem_addr));

    p_linear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && advance && !order_il && lin_only && steps != 2'd3)
        |=> mem_addr[1:0] == $past(mem_addr[1:0]) + 2'd1);

    p_xor_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && advance && order_il && il_only && steps != 2'd3)
        |=> mem_addr[1:0] == ($past(mem_addr[1:0]) ^
                              (($past(steps) == 2'd1) ? 2'd3 : 2'd1)));

    p_upper_r7: assert property (@(posedge clk) disable iff (!rst_n)
        quiet |=> mem_addr[AW-1:2] == $past(mem_addr[AW-1:2]));

    p_saturate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && steps == 2'd3) |=> $stable(mem_addr));

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (quiet && !advance) |=> $stable(mem_addr));
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.AW(AW), .NCE(NCE)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ext_addr    (ext_addr),
    .strobe_proc (strobe_proc),
    .strobe_ctl  (strobe_ctl),
    .chip_en     (chip_en),
    .advance     (advance),
    .order_il    (order_il),
    .mem_addr    (mem_addr)
);

// File: tb/burst_addr_seq_tb.sv
// Bench: behavioural model compared with the design on every clock.
module burst_addr_seq_tb;
    localparam int AW  = 18;
    localparam int NCE = 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [AW-1:0]  ext_addr = '0;
    logic           strobe_proc = 1'b0;
    logic           strobe_ctl = 1'b0;
    logic [NCE-1:0] chip_en = '0;
    logic           advance = 1'b0;
    logic           order_il = 1'b1;
    logic [AW-1:0]  mem_addr;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    int m_addr  = 0;
    int m_start = 0;
    int m_cnt   = 0;

    always #2 clk = ~clk;  // 250 MHz

    burst_addr_seq #(.AW(AW), .NCE(NCE)) u_dut (
        .clk(clk), .rst_n(rst_n), .ext_addr(ext_addr),
        .strobe_proc(strobe_proc), .strobe_ctl(strobe_ctl),
        .chip_en(chip_en), .advance(advance), .order_il(order_il),
        .mem_addr(mem_addr)
    );

    // Model update for one edge, using the inputs driven for that edge.
    task automatic model_edge();
        int lo;
        if (!rst_n) begin
            m_addr = 0; m_start = 0; m_cnt = 0;
        end else if ((strobe_proc && chip_en[0]) ||
                     (strobe_ctl && chip_en == {NCE{1'b1}})) begin
            m_addr = int'(ext_addr); m_start = int'(ext_addr) % 4; m_cnt = 0;
        end else if (!strobe_proc && !strobe_ctl && advance && m_cnt < 3) begin
            m_cnt = m_cnt + 1;
            lo = order_il ? (m_start ^ m_cnt) : ((m_start + m_cnt) % 4);
            m_addr = (m_addr / 4) * 4 + lo;
        end
    endtask

    // One cycle: drive, clock, then compare at the falling edge.
    task automatic cyc(input bit p, input bit c, input logic [NCE-1:0] ce,
                       input bit adv, input bit il, input int a,
                       input string tag);
        strobe_proc = p; strobe_ctl = c; chip_en = ce;
        advance = adv; order_il = il; ext_addr = AW'(a);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        n_cmp++;
        if (mem_addr !== AW'(m_addr)) begin
            n_bad++;
            $display("FAIL %s: mem_addr=%h expected=%h", tag, mem_addr,
                     AW'(m_addr));
        end
    endtask

    initial begin
        @(negedge clk);
        rst_n = 1'b0;
        cyc(0, 0, '1, 1, 0, 0, "R1 in reset");
        cyc(1, 0, '1, 0, 0, 'h155, "R1 in reset");
        rst_n = 1'b1;
        cyc(0, 0, '0, 0, 0, 0, "R1 after reset");
        cyc(0, 0, '0, 0, 1, 0, "R9 hold");
        // Steps straight from reset, then saturation.
        cyc(0, 0, '0, 1, 0, 0, "R5 step1");
        cyc(0, 0, '0, 1, 0, 0, "R5 step2");
        cyc(0, 0, '0, 1, 0, 0, "R5 step3");
        cyc(0, 0, '0, 1, 0, 0, "R8 saturated");
        cyc(0, 0, '0, 1, 1, 0, "R8 saturated");
        // Processor load, start 2, counting order.
        cyc(1, 0, 3'b001, 0, 0, 'h2ABCE, "R2 load");
        cyc(0, 0, '0, 1, 0, 0, "R5 lin 3");
        cyc(0, 0, '0, 0, 0, 0, "R9 hold mid-burst");
        cyc(0, 0, '0, 1, 0, 0, "R5 R7 lin 0 no carry");
        cyc(0, 0, '0, 1, 0, 0, "R5 lin 1");
        cyc(0, 0, '0, 1, 0, 0, "R8 hold");
        // Controller load, start 1, XOR order.
        cyc(0, 1, '1, 0, 1, 'h12345, "R3 load");
        cyc(0, 0, '0, 1, 1, 0, "R6 xor 0");
        cyc(0, 0, '0, 1, 1, 0, "R6 xor 3");
        cyc(0, 0, '0, 1, 1, 0, "R6 xor 2");
        cyc(0, 0, '0, 1, 1, 0, "R8 hold");
        // XOR order, start 2.
        cyc(0, 1, '1, 0, 1, 'h0AAA6, "R3 load");
        cyc(0, 0, '0, 1, 1, 0, "R6 xor 3");
        cyc(0, 0, '0, 1, 1, 0, "R6 R7 xor 0");
        cyc(0, 0, '0, 1, 1, 0, "R6 xor 1");
        // Priority: both strobes, only primary enable.
        cyc(1, 1, 3'b001, 1, 0, 'h3FFF3, "R2 priority");
        cyc(0, 0, '0, 1, 0, 0, "R5 R7 lin 0 no carry");
        // Unqualified strobes with advance high.
        cyc(0, 1, 3'b011, 1, 0, 'h11111, "R4 ctl unqualified");
        cyc(1, 0, 3'b110, 1, 0, 'h22222, "R4 proc unqualified");
        cyc(1, 1, 3'b110, 1, 1, 'h33333, "R4 both unqualified");
        cyc(0, 0, '0, 1, 0, 0, "R5 lin 1");
        // Randomized mix.
        for (int i = 0; i < 400; i++) begin
            cyc(($urandom % 5) == 0, ($urandom % 5) == 0,
                NCE'($urandom | (($urandom % 3 == 0) ? 0 : 7)),
                ($urandom % 4) != 0, ($urandom % 8) == 0 ? ~order_il : order_il,
                int'($urandom % (1 << AW)), "R2/R3/R4/R5/R6/R7/R8/R9 mixed");
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule